// File: doc/BRIEF.md
# Down-Counting Compare Timer

This block is a memory-mapped timer built around a counter that counts down. An input tick, divided by a programmable prescaler, decrements the counter while the run bit is set. A compare register is matched against the counter. When a decrement lands on the compare value, the block does three things. It sets a sticky status flag. It can assert a level interrupt. It can drive an output pin high, drive it low or toggle it.

Software reads the counter to measure elapsed time. To schedule a one-shot event, software writes (current count minus delta) into the compare register, and the match then arrives delta prescaled ticks later. When the counter reaches zero it either wraps to all ones or reloads from the load register. The run bit can either resume counting from the held value or restart from the load value. A control bit lets a write to the load register also overwrite the counter. A self-clearing control bit returns every register to zero.

The bus is a single-cycle word-addressed write port with combinational read data for the addressed word.

Top module: `cmp_timer`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `cmp_out` is 0.
- R2: Word 0 is control, word 1 is status, word 2 is load, word 3 is compare and word 4 is counter. Control reads back only bits 0-15, 17, 22 and 23 (mask 0x00C2FFFF). Status reads back only bit 0. Words 5 to 7 read 0.
- R3: The prescaler value sits in control bits 15:4. The counter steps once every (value+1) cycles in which `tick_en` is 1, and only while control bit 0 (run) is 1. With `tick_en` at 0 or run at 0, the counter holds.
- R4: Each step decrements the counter by one. A step taken at zero gives 0xFFFFFFFF when control bit 3 (reload) is 0.
- R5: A step taken at zero with control bit 3 set loads the counter from the load register.
- R6: When a step leaves the counter equal to the compare register, status bit 0 is set on that same edge. Writing compare as (count minus d) therefore gives a match d steps later.
- R7: Writing status with bit 0 = 1 clears the flag. Writing 0 has no effect. A match on the same edge wins over the clear.
- R8: `irq` equals status bit 0 AND control bit 2, as a level.
- R9: Control bits 23:22 set what a match does to `cmp_out`: 0 leaves it unchanged, 1 toggles it, 2 drives it 0 and 3 drives it 1.
- R10: A write that sets control bit 0 while it was 0 loads the counter from the load register if the same write also sets bit 1. If bit 1 is 0, counting resumes from the held value.
- R11: While control bit 17 is set, a write to the load register also writes the counter, taking priority over a step on that edge.
- R12: A control write with bit 16 set clears every register, the prescaler and `cmp_out` on that edge. Bit 16 always reads 0.
- R13: Writes to the counter word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Qualifies the input tick (clock-source enable) |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_word | input | 3 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| irq | output | 1 | Level compare interrupt |
| cmp_out | output | 1 | Compare-driven output pin |

## Verification
The bench targets the zero crossing in both the wrap and reload settings; a wrong design would land on 0 or 0xFFFFFFFE, or ignore the load value. It clears the flag on the very edge a match arrives. A design that lets the clear win would lose an event, and the interrupt would never be seen. It also checks the prescaler period and `tick_en` gating, where an off-by-one shows up as a shifted count after a fixed number of cycles. It checks both senses of the enable mode, where a wrong design restarts when it should resume. Finally, it issues the software reset after the pin has been driven high; an incomplete clear leaves the pin or a register nonzero.

// File: rtl/ct_pkg.sv
`timescale 1ns/1ps
package ct_pkg;
    localparam int DATA_W = 32;
    localparam int WORD_W = 3;
    localparam int PRE_W  = 12;

    localparam logic [WORD_W-1:0] W_CTRL   = 3'd0;
    localparam logic [WORD_W-1:0] W_STATUS = 3'd1;
    localparam logic [WORD_W-1:0] W_LOAD   = 3'd2;
    localparam logic [WORD_W-1:0] W_CMP    = 3'd3;
    localparam logic [WORD_W-1:0] W_COUNT  = 3'd4;

    localparam int CB_RUN     = 0;
    localparam int CB_RESTART = 1;
    localparam int CB_IRQEN   = 2;
    localparam int CB_RELOAD  = 3;
    localparam int CB_DIV     = 4;
    localparam int CB_SWRST   = 16;
    localparam int CB_OVW     = 17;
    localparam int CB_OMODE   = 22;

    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h00C2_FFFF;

    typedef enum logic [1:0] {
        OM_HOLD   = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_LOW    = 2'd2,
        OM_HIGH   = 2'd3
    } out_mode_t;
endpackage

// File: rtl/ct_prescaler.sv
`timescale 1ns/1ps
module ct_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic             tick_en_i,
    input  logic [PRE_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [PRE_W-1:0] pcnt;
    } pre_state_t;

    localparam logic [PRE_W-1:0] ONE = {{(PRE_W-1){1'b0}}, 1'b1};

    pre_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        tick_o = run_i && tick_en_i && (s_q.pcnt >= div_i);
        if (clr_i || !run_i) begin
            s_d.pcnt = '0;
        end else if (tick_en_i) begin
            s_d.pcnt = tick_o ? '0 : s_q.pcnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: a gated cycle never advances the divider
    assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_en_i && !clr_i) |=> $stable(s_q.pcnt));
    // R3: the divider restarts after a step
    assert_div_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (s_q.pcnt == '0));
endmodule

// File: rtl/ct_counter.sv
`timescale 1ns/1ps
module ct_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic             reload_i,
    input  logic             ovw_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic [CNT_W-1:0] ovw_val_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_state_t       s_d, s_q;
    logic [CNT_W-1:0] step_val;
    logic             plain_step;

    always_comb begin
        s_d        = s_q;
        match_o    = 1'b0;
        plain_step = 1'b0;
        if (s_q.cnt == '0) begin
            step_val = reload_i ? load_i : '1;
        end else begin
            step_val = s_q.cnt - ONE;
        end
        if (clr_i) begin
            s_d.cnt = '0;
        end else if (ovw_i) begin
            s_d.cnt = ovw_val_i;
        end else if (restart_i) begin
            s_d.cnt = load_i;
        end else if (tick_i) begin
            plain_step = 1'b1;
            s_d.cnt    = step_val;
            match_o    = (step_val == cmp_i);
        end
    end

    assign cnt_o = s_q.cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i && !ovw_i && !restart_i) |=> $stable(s_q.cnt));
    assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_step && s_q.cnt != '0) |=> (s_q.cnt == $past(s_q.cnt) - ONE));
    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_step && s_q.cnt == '0 && !reload_i) |=> (&s_q.cnt));
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_step && s_q.cnt == '0 && reload_i) |=> (s_q.cnt == $past(load_i)));
    assert_overwrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovw_i && !clr_i) |=> (s_q.cnt == $past(ovw_val_i)));
    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && !clr_i && !ovw_i) |=> (s_q.cnt == $past(load_i)));
    assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (s_q.cnt == '0));
endmodule

// File: rtl/ct_regs.sv
`timescale 1ns/1ps
module ct_regs
    import ct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_word,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              match_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              run_o,
    output logic              reload_o,
    output logic [PRE_W-1:0]  div_o,
    output logic              swr_o,
    output logic              ovw_o,
    output logic              restart_o,
    output logic [CNT_W-1:0]  ovw_val_o,
    output logic [CNT_W-1:0]  load_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              irq_o,
    output logic              pin_o
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [CNT_W-1:0]  load;
        logic [CNT_W-1:0]  cmp;
        logic              flag;
        logic              pin;
    } reg_state_t;

    reg_state_t s_d, s_q;
    out_mode_t  omode;
    logic       wr_ctrl, wr_stat, wr_load, wr_cmp;

    assign wr_ctrl = bus_we && (bus_word == W_CTRL);
    assign wr_stat = bus_we && (bus_word == W_STATUS);
    assign wr_load = bus_we && (bus_word == W_LOAD);
    assign wr_cmp  = bus_we && (bus_word == W_CMP);

    assign omode     = out_mode_t'(s_q.ctrl[CB_OMODE+1:CB_OMODE]);
    assign run_o     = s_q.ctrl[CB_RUN];
    assign reload_o  = s_q.ctrl[CB_RELOAD];
    assign div_o     = s_q.ctrl[CB_DIV+PRE_W-1:CB_DIV];
    assign swr_o     = wr_ctrl && bus_wdata[CB_SWRST];
    assign ovw_o     = wr_load && s_q.ctrl[CB_OVW];
    assign restart_o = wr_ctrl && bus_wdata[CB_RUN] && bus_wdata[CB_RESTART]
                       && !s_q.ctrl[CB_RUN];
    assign ovw_val_o = bus_wdata[CNT_W-1:0];
    assign load_o    = s_q.load;
    assign cmp_o     = s_q.cmp;
    assign irq_o     = s_q.flag && s_q.ctrl[CB_IRQEN];
    assign pin_o     = s_q.pin;

    always_comb begin
        s_d = s_q;
        if (wr_ctrl) s_d.ctrl = bus_wdata & CTRL_MASK;
        if (wr_load) s_d.load = bus_wdata[CNT_W-1:0];
        if (wr_cmp)  s_d.cmp  = bus_wdata[CNT_W-1:0];
        if (wr_stat && bus_wdata[0]) s_d.flag = 1'b0;
        if (match_i) begin
            s_d.flag = 1'b1;
            unique case (omode)
                OM_HOLD:   s_d.pin = s_q.pin;
                OM_TOGGLE: s_d.pin = !s_q.pin;
                OM_LOW:    s_d.pin = 1'b0;
                OM_HIGH:   s_d.pin = 1'b1;
            endcase
        end
        if (swr_o) s_d = '0;
    end

    always_comb begin
        rdata_o = '0;
        case (bus_word)
            W_CTRL:   rdata_o = s_q.ctrl;
            W_STATUS: rdata_o = {{(DATA_W-1){1'b0}}, s_q.flag};
            W_LOAD:   rdata_o = DATA_W'(s_q.load);
            W_CMP:    rdata_o = DATA_W'(s_q.cmp);
            W_COUNT:  rdata_o = DATA_W'(cnt_i);
            default:  rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && !swr_o) |=> s_q.flag);
    assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flag) |-> $past(match_i));
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && bus_wdata[0] && !match_i) |=> !s_q.flag);
    assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && !swr_o && s_q.ctrl[CB_IRQEN] && !wr_ctrl) |=> irq_o);
    assert_pin_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && !swr_o && omode == OM_HIGH) |=> pin_o);
    assert_pin_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && omode == OM_LOW) |=> !pin_o);
    assert_pin_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && !swr_o && omode == OM_TOGGLE) |=> (pin_o != $past(pin_o)));
    assert_swr_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        swr_o |=> (s_q.ctrl == '0 && s_q.load == '0 && !pin_o && !s_q.flag));
endmodule

// File: rtl/cmp_timer.sv
`timescale 1ns/1ps
module cmp_timer
    import ct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_word,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              cmp_out
);
    logic             run, reload, swr, ovw, restart, tick, match;
    logic [PRE_W-1:0] div;
    logic [CNT_W-1:0] ovw_val, load_val, cmp_val, cnt_val;

    ct_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .match_i   (match),
        .cnt_i     (cnt_val),
        .rdata_o   (bus_rdata),
        .run_o     (run),
        .reload_o  (reload),
        .div_o     (div),
        .swr_o     (swr),
        .ovw_o     (ovw),
        .restart_o (restart),
        .ovw_val_o (ovw_val),
        .load_o    (load_val),
        .cmp_o     (cmp_val),
        .irq_o     (irq),
        .pin_o     (cmp_out)
    );

    ct_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (swr),
        .run_i     (run),
        .tick_en_i (tick_en),
        .div_i     (div),
        .tick_o    (tick)
    );

    ct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (swr),
        .tick_i    (tick),
        .reload_i  (reload),
        .ovw_i     (ovw),
        .restart_i (restart),
        .load_i    (load_val),
        .ovw_val_i (ovw_val),
        .cmp_i     (cmp_val),
        .cnt_o     (cnt_val),
        .match_o   (match)
    );

    // R13: a write to the counter word changes nothing when no step is due
    assert_count_ro_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_word == W_COUNT && !tick) |=> $stable(cnt_val));
endmodule

// File: tb/tb_cmp_timer.sv
`timescale 1ns/1ps
module tb_cmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_word = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq, cmp_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    cmp_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .cmp_out(cmp_out)
    );

    always #2.5 clk = ~clk;

    // Reference state derived from the requirements
    logic [31:0] m_ctrl, m_load, m_cmp, m_cnt;
    logic [11:0] m_pc;
    logic        m_flag, m_pin;

    always @(posedge clk) begin : model
        logic        tk, rs, ow, hit;
        logic [31:0] step, nctrl, nload, ncmp, ncnt;
        logic [11:0] npc;
        logic        nflag, npin;
        if (!rst_n) begin
            m_ctrl <= 0; m_load <= 0; m_cmp <= 0; m_cnt <= 0;
            m_pc <= 0; m_flag <= 0; m_pin <= 0;
        end else begin
            tk   = m_ctrl[0] && tick_en && (m_pc >= m_ctrl[15:4]);
            npc  = !m_ctrl[0] ? 12'd0 : (tick_en ? (tk ? 12'd0 : m_pc + 12'd1) : m_pc);
            step = (m_cnt == 0) ? (m_ctrl[3] ? m_load : 32'hFFFF_FFFF) : m_cnt - 1;
            nctrl = m_ctrl; nload = m_load; ncmp = m_cmp; ncnt = m_cnt;
            nflag = m_flag; npin = m_pin; hit = 1'b0;
            rs = bus_we && bus_word == 0 && bus_wdata[0] && bus_wdata[1] && !m_ctrl[0];
            ow = bus_we && bus_word == 2 && m_ctrl[17];
            if (bus_we) begin
                case (bus_word)
                    3'd0: nctrl = bus_wdata & 32'h00C2_FFFF;
                    3'd1: if (bus_wdata[0]) nflag = 1'b0;
                    3'd2: nload = bus_wdata;
                    3'd3: ncmp = bus_wdata;
                    default: ;
                endcase
            end
            if (ow) ncnt = bus_wdata;
            else if (rs) ncnt = m_load;
            else if (tk) begin ncnt = step; hit = (step == m_cmp); end
            if (hit) begin
                nflag = 1'b1;
                case (m_ctrl[23:22])
                    2'd1: npin = !m_pin;
                    2'd2: npin = 1'b0;
                    2'd3: npin = 1'b1;
                    default: ;
                endcase
            end
            if (bus_we && bus_word == 0 && bus_wdata[16]) begin
                nctrl = 0; nload = 0; ncmp = 0; ncnt = 0; npc = 0; nflag = 0; npin = 0;
            end
            m_ctrl <= nctrl; m_load <= nload; m_cmp <= ncmp; m_cnt <= ncnt;
            m_pc <= npc; m_flag <= nflag; m_pin <= npin;
        end
    end

    function automatic logic [31:0] model_read(input logic [2:0] w);
        case (w)
            3'd0: return m_ctrl;
            3'd1: return {31'd0, m_flag};
            3'd2: return m_load;
            3'd3: return m_cmp;
            3'd4: return m_cnt;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle_checks();
        chk("R8 irq level", {31'd0, irq}, {31'd0, m_flag && m_ctrl[2]});
        chk("R9 pin", {31'd0, cmp_out}, {31'd0, m_pin});
        chk("R2 read data", bus_rdata, model_read(bus_word));
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        if (rst_n) cycle_checks();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [2:0] w, input logic [31:0] d);
        bus_we = 1'b1; bus_word = w; bus_wdata = d;
        cyc();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] w, input logic [31:0] exp, input string tag);
        bus_word = w;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        for (int w = 0; w < 5; w++) rd(w[2:0], 32'd0, "R1 reset register");
        chk("R1 reset irq", {31'd0, irq}, 32'd0);
        chk("R1 reset pin", {31'd0, cmp_out}, 32'd0);
        // R2 map and masks
        wr(3'd0, 32'hFFFE_FFFC);
        rd(3'd0, 32'h00C2_FFFC, "R2 control mask");
        wr(3'd0, 32'd0);
        wr(3'd3, 32'hA5A5_0001);
        rd(3'd3, 32'hA5A5_0001, "R2 compare word");
        rd(3'd5, 32'd0, "R2 unmapped word");
        // R13 counter write ignored
        wr(3'd4, 32'h1234);
        rd(3'd4, 32'd0, "R13 counter read-only");
        // R11 overwrite, R4 wrap
        wr(3'd0, 32'h0002_0000);
        wr(3'd2, 32'd5);
        rd(3'd4, 32'd5, "R11 load overwrites counter");
        wr(3'd0, 32'h0000_0001);
        idle(5);
        wr(3'd0, 32'd0);
        rd(3'd4, 32'hFFFF_FFFF, "R4 wrap past zero");
        // R5 reload
        wr(3'd0, 32'h0002_0000);
        wr(3'd2, 32'd3);
        wr(3'd0, 32'h0002_0009);
        idle(3);
        wr(3'd0, 32'd0);
        rd(3'd4, 32'd3, "R5 reload at zero");
        // R3 prescaler divide by 4
        wr(3'd0, 32'h0002_0000);
        wr(3'd2, 32'd100);
        wr(3'd0, 32'h0002_0031);
        idle(19);
        wr(3'd0, 32'd0);
        rd(3'd4, 32'd95, "R3 divide by four");
        tick_en = 1'b0;
        wr(3'd0, 32'h0000_0001);
        idle(10);
        wr(3'd0, 32'd0);
        tick_en = 1'b1;
        rd(3'd4, 32'd95, "R3 tick_en gating");
        // R6 R8 R9 match
        wr(3'd0, 32'h0002_0000);
        wr(3'd2, 32'd20);
        wr(3'd3, 32'd15);
        wr(3'd0, 32'h00C2_0005);
        idle(4);
        chk("R6 no flag before match", {31'd0, irq}, 32'd0);
        idle(1);
        chk("R8 irq on match", {31'd0, irq}, 32'd1);
        chk("R9 set mode pin", {31'd0, cmp_out}, 32'd1);
        wr(3'd1, 32'd0);
        rd(3'd1, 32'd1, "R7 write zero no effect");
        wr(3'd1, 32'd1);
        rd(3'd1, 32'd0, "R7 write one clears");
        // R7 clear and match on the same edge: match wins; R6 delta scheduling
        wr(3'd3, m_cnt - 32'd3);
        idle(1);
        wr(3'd1, 32'd1);
        rd(3'd1, 32'd1, "R7 match beats clear");
        // R10 restart vs resume
        wr(3'd0, 32'd0);
        wr(3'd2, 32'd50);
        wr(3'd0, 32'h0000_0003);
        wr(3'd0, 32'h0000_0002);
        rd(3'd4, 32'd49, "R10 restart from load");
        wr(3'd0, 32'h0000_0001);
        wr(3'd0, 32'd0);
        rd(3'd4, 32'd48, "R10 resume from held");
        // R12 software reset
        wr(3'd3, 32'd1);
        wr(3'd0, 32'h0001_0000);
        for (int w = 0; w < 5; w++) rd(w[2:0], 32'd0, "R12 soft reset clears");
        chk("R12 pin cleared", {31'd0, cmp_out}, 32'd0);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            r = $urandom;
            tick_en = ($urandom % 5) != 0;
            bus_word = 3'($urandom % 6);
            bus_we = 1'b0;
            case (r % 10)
                0: begin bus_we = 1'b1; bus_word = 3'd3; bus_wdata = m_cnt - (1 + $urandom % 8); end
                1: begin bus_we = 1'b1; bus_word = 3'd1; bus_wdata = $urandom; end
                2: begin
                    bus_we = 1'b1; bus_word = 3'd0;
                    bus_wdata = ($urandom & 32'hFFC2_000F) | (($urandom % 4) << 4);
                    if ($urandom % 40 == 0) bus_wdata[16] = 1'b1;
                end
                3: begin bus_we = 1'b1; bus_word = 3'd2; bus_wdata = $urandom % 40; end
                4: begin bus_we = 1'b1; bus_word = 3'd4; bus_wdata = $urandom; end
                default: ;
            endcase
            cyc();
        end
        bus_we = 1'b0;
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule